// File: doc/BRIEF.md
# Branch Condition and Target Unit

This purely combinational unit sits between instruction decode and the fetch stage of a small 8-bit controller core. From the current C, Z, S and V flags, a 4-bit condition field and a branch kind, it decides whether a control transfer happens. It also produces the program counter for the following fetch. Five kinds of transfer are handled:

- a conditional jump to an absolute 16-bit target;
- a conditional jump to a target relative to the next instruction;
- a relative jump taken when a tested bit is clear;
- a relative jump taken when a tested bit is set;
- a loop form that decrements a counter byte and jumps while the decremented value is non-zero.

Decode presents the instruction's fields, and the unit returns the taken decision, the next PC and the decremented counter in the same cycle. Decode writes the counter back to the register file. Pushing return addresses and fetching instructions are handled by other blocks.

Top module: `branch_unit`

## Requirements
- R1: For kinds 0 and 1, condition code 4'b0000 is never taken and 4'b1000 is always taken, whatever the flags.
- R2: Single-flag codes: 4'b0111 is taken when C=1 and 4'b1111 when C=0. 4'b0110 is taken when Z=1 and 4'b1110 when Z=0. 4'b0101 is taken when S=1 and 4'b1101 when S=0. 4'b0100 is taken when V=1 and 4'b1100 when V=0.
- R3: Signed codes: 4'b0001 is taken when S^V=1 and 4'b1001 when S^V=0. 4'b0010 is taken when Z|(S^V)=1 and 4'b1010 when it is 0.
- R4: Unsigned codes: 4'b0011 is taken when C|Z=1, and 4'b1011 is taken when C=0 and Z=0.
- R5: Kind 3'd0 is the absolute conditional jump. When taken, nextPc equals absTarget.
- R6: Kind 3'd1 is the relative conditional jump. When taken, nextPc equals seqPc plus disp sign-extended, with disp read as two's complement (-128..+127). The sum wraps modulo 65536.
- R7: Kind 3'd2 is taken when testBit=0, and kind 3'd3 is taken when testBit=1. Both ignore condCode and flags and use the relative target of R6.
- R8: cntNext always equals loopCnt minus one, modulo 256. Kind 3'd4 is taken exactly when that value is non-zero, ignores condCode and flags, and uses the relative target of R6.
- R9: When the transfer is not taken, nextPc equals seqPc. Kinds 3'd5 to 3'd7 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flagC | input | 1 | Carry flag |
| flagZ | input | 1 | Zero flag |
| flagS | input | 1 | Sign flag |
| flagV | input | 1 | Overflow flag |
| condCode | input | 4 | Condition field of the instruction |
| brKind | input | 3 | Transfer kind (0 abs cond, 1 rel cond, 2 bit clear, 3 bit set, 4 loop) |
| seqPc | input | 16 | Address of the next sequential instruction |
| disp | input | 8 | Signed relative displacement |
| absTarget | input | 16 | Absolute jump target |
| testBit | input | 1 | Value of the bit under test |
| loopCnt | input | 8 | Loop counter byte before decrement |
| taken | output | 1 | Transfer is taken |
| nextPc | output | 16 | Address of the next fetch |
| cntNext | output | 8 | Decremented loop counter |

## Verification
The bench builds the unit with its default widths: a 16-bit PC, an 8-bit displacement and an 8-bit counter. With these widths the address space is small enough to reach both ends. The relative sum can cross 0xFFFF to 0x0000 and drop below 0x0000. The displacement extremes -128 and +127 are covered, and the counter can wrap from 0 to 0xFF. The condition table is swept over all 256 combinations of code and flags.

// File: rtl/branch_pkg.sv
package branch_pkg;
  typedef enum logic [2:0] {
    KIND_ABS_CC = 3'd0,
    KIND_REL_CC = 3'd1,
    KIND_BIT_LO = 3'd2,
    KIND_BIT_HI = 3'd3,
    KIND_LOOP   = 3'd4
  } branch_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;
    logic selAbs;
  } branch_strobe_t;
endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_pkg::*;
(
  input  logic           flagC,
  input  logic           flagZ,
  input  logic           flagS,
  input  logic           flagV,
  input  logic [3:0]     condCode,
  input  logic [2:0]     brKind,
  input  logic           testBit,
  input  logic           cntNonZero,
  output branch_strobe_t strobe
);
  logic baseCond;
  logic condTrue;

  // low three bits pick a flag expression, the top bit inverts it
  always_comb begin
    unique case (condCode[2:0])
      3'd0: baseCond = 1'b0;
      3'd1: baseCond = flagS ^ flagV;
      3'd2: baseCond = flagZ | (flagS ^ flagV);
      3'd3: baseCond = flagC | flagZ;
      3'd4: baseCond = flagV;
      3'd5: baseCond = flagS;
      3'd6: baseCond = flagZ;
      default: baseCond = flagC;
    endcase
    condTrue = baseCond ^ condCode[3];
  end

  always_comb begin
    strobe = '0;
    unique case (brKind)
      KIND_ABS_CC: begin strobe.take = condTrue; strobe.selAbs = 1'b1; end
      KIND_REL_CC: strobe.take = condTrue;
      KIND_BIT_LO: strobe.take = ~testBit;
      KIND_BIT_HI: strobe.take = testBit;
      KIND_LOOP:   strobe.take = cntNonZero;
      default:     strobe.take = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({brKind, condCode, strobe.take})) begin
      if (brKind <= 3'd1 && condCode == 4'b0000)
        AST_NEVER_CODE: assert (!strobe.take); // R1
      if (brKind <= 3'd1 && condCode == 4'b1000)
        AST_ALWAYS_CODE: assert (strobe.take); // R1
      if (brKind >= 3'd5)
        AST_RESERVED_KIND: assert (!strobe.take); // R9
    end
    if (!$isunknown({brKind, testBit, strobe.take})) begin
      if (brKind == 3'd2)
        AST_BIT_CLEAR: assert (strobe.take == !testBit); // R7
      if (brKind == 3'd3)
        AST_BIT_SET: assert (strobe.take == testBit); // R7
    end
  end
endmodule

// File: rtl/branch_dp.sv
module branch_dp
  import branch_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int CNT_W  = 8
) (
  input  branch_strobe_t    strobe,
  input  logic [PC_W-1:0]   seqPc,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   absTarget,
  input  logic [CNT_W-1:0]  loopCnt,
  output logic [PC_W-1:0]   nextPc,
  output logic [CNT_W-1:0]  cntNext,
  output logic              cntNonZero
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] dispExt;
  logic [PC_W-1:0] relTarget;

  assign dispExt    = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign relTarget  = seqPc + dispExt;
  assign cntNext    = loopCnt - CNT_W'(1);
  assign cntNonZero = |cntNext;

  always_comb begin
    if (!strobe.take)       nextPc = seqPc;
    else if (strobe.selAbs) nextPc = absTarget;
    else                    nextPc = relTarget;
  end

  always_comb begin
    if (!$isunknown({strobe, seqPc, nextPc})) begin
      if (!strobe.take)
        AST_FALL_THROUGH: assert (nextPc == seqPc); // R9
    end
    if (!$isunknown({strobe, absTarget, nextPc})) begin
      if (strobe.take && strobe.selAbs)
        AST_ABS_TARGET: assert (nextPc == absTarget); // R5
    end
    if (!$isunknown({loopCnt, cntNonZero})) begin
      AST_LOOP_LAST: assert ((loopCnt == CNT_W'(1)) == !cntNonZero); // R8
    end
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              flagC,
  input  logic              flagZ,
  input  logic              flagS,
  input  logic              flagV,
  input  logic [3:0]        condCode,
  input  logic [2:0]        brKind,
  input  logic [PC_W-1:0]   seqPc,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   absTarget,
  input  logic              testBit,
  input  logic [CNT_W-1:0]  loopCnt,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc,
  output logic [CNT_W-1:0]  cntNext
);
  branch_strobe_t strobe;
  logic           cntNonZero;

  branch_ctrl u_ctrl (
    .flagC(flagC), .flagZ(flagZ), .flagS(flagS), .flagV(flagV),
    .condCode(condCode), .brKind(brKind), .testBit(testBit),
    .cntNonZero(cntNonZero), .strobe(strobe)
  );

  branch_dp #(.PC_W(PC_W), .DISP_W(DISP_W), .CNT_W(CNT_W)) u_dp (
    .strobe(strobe), .seqPc(seqPc), .disp(disp), .absTarget(absTarget),
    .loopCnt(loopCnt), .nextPc(nextPc), .cntNext(cntNext),
    .cntNonZero(cntNonZero)
  );

  assign taken = strobe.take;
endmodule

// File: tb/branch_unit_bench.sv
`timescale 1ns/1ps
module branch_unit_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        flagC, flagZ, flagS, flagV, testBit, taken;
  logic [3:0]  condCode;
  logic [2:0]  brKind;
  logic [15:0] seqPc, absTarget, nextPc;
  logic [7:0]  disp, loopCnt, cntNext;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  branch_unit u_branch_unit (
    .flagC(flagC), .flagZ(flagZ), .flagS(flagS), .flagV(flagV),
    .condCode(condCode), .brKind(brKind), .seqPc(seqPc), .disp(disp),
    .absTarget(absTarget), .testBit(testBit), .loopCnt(loopCnt),
    .taken(taken), .nextPc(nextPc), .cntNext(cntNext)
  );

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit expCond(logic [3:0] cc, logic c, logic z, logic s, logic v);
    case (cc)
      4'b0000: return 1'b0;
      4'b1000: return 1'b1;
      4'b0111: return c;
      4'b1111: return !c;
      4'b0110: return z;
      4'b1110: return !z;
      4'b0101: return s;
      4'b1101: return !s;
      4'b0100: return v;
      4'b1100: return !v;
      4'b0001: return s != v;
      4'b1001: return s == v;
      4'b0010: return z || (s != v);
      4'b1010: return !(z || (s != v));
      4'b0011: return c || z;
      default: return !c && !z;
    endcase
  endfunction

  function automatic string reqOf(logic [3:0] cc);
    case (cc[2:0])
      3'd0: return "R1";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic t_idle();
    {flagC, flagZ, flagS, flagV, testBit} = '0;
    condCode = 4'b0000; brKind = 3'd1;
    seqPc = 16'h1234; disp = 8'h10; absTarget = 16'h0; loopCnt = 8'h05;
    settle();
    chk("R1 idle taken", {15'd0, taken}, 16'd0);
    chk("R9 idle pc", nextPc, 16'h1234);
  endtask

  task automatic t_table();
    brKind = 3'd1; seqPc = 16'h4000; disp = 8'h20;
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        condCode = cc[3:0];
        {flagC, flagZ, flagS, flagV} = f[3:0];
        settle();
        begin
          bit e = expCond(cc[3:0], f[3], f[2], f[1], f[0]);
          chk(reqOf(cc[3:0]), {15'd0, taken}, {15'd0, e});
          chk(e ? "R6 table pc" : "R9 table pc", nextPc, e ? 16'h4020 : 16'h4000);
        end
      end
    end
  endtask

  task automatic t_absolute();
    brKind = 3'd0; absTarget = 16'hBEEF; seqPc = 16'h0100;
    {flagC, flagZ, flagS, flagV} = 4'b1000;
    condCode = 4'b0111; settle();
    chk("R5 abs taken", nextPc, 16'hBEEF);
    condCode = 4'b1111; settle();
    chk("R9 abs not taken", nextPc, 16'h0100);
    condCode = 4'b1000; settle();
    chk("R1 abs always", {15'd0, taken}, 16'd1);
  endtask

  task automatic t_relative();
    brKind = 3'd1; condCode = 4'b1000;
    seqPc = 16'h1000; disp = 8'h80; settle();
    chk("R6 disp -128", nextPc, 16'h0F80);
    disp = 8'h7F; settle();
    chk("R6 disp +127", nextPc, 16'h107F);
    seqPc = 16'hFFF0; disp = 8'h7F; settle();
    chk("R6 wrap up", nextPc, 16'h006F);
    seqPc = 16'h0010; disp = 8'hE0; settle();
    chk("R6 wrap down", nextPc, 16'hFFF0);
  endtask

  task automatic t_bittest();
    seqPc = 16'h2000; disp = 8'h08; condCode = 4'b0000;
    {flagC, flagZ, flagS, flagV} = 4'b0000;
    brKind = 3'd2; testBit = 1'b0; settle();
    chk("R7 false form taken", nextPc, 16'h2008);
    testBit = 1'b1; settle();
    chk("R7 false form skip", {15'd0, taken}, 16'd0);
    brKind = 3'd3; settle();
    chk("R7 true form taken", nextPc, 16'h2008);
    testBit = 1'b0; settle();
    chk("R7 true form skip", nextPc, 16'h2000);
  endtask

  task automatic t_loop();
    brKind = 3'd4; seqPc = 16'h3000; disp = 8'hFC; condCode = 4'b0000;
    loopCnt = 8'h05; settle();
    chk("R8 cnt dec", {8'd0, cntNext}, 16'h0004);
    chk("R8 loop taken", nextPc, 16'h2FFC);
    loopCnt = 8'h01; settle();
    chk("R8 last pass cnt", {8'd0, cntNext}, 16'h0000);
    chk("R8 last pass pc", nextPc, 16'h3000);
    loopCnt = 8'h00; settle();
    chk("R8 wrap cnt", {8'd0, cntNext}, 16'h00FF);
    chk("R8 wrap taken", {15'd0, taken}, 16'd1);
  endtask

  task automatic t_reserved();
    condCode = 4'b1000; testBit = 1'b1; loopCnt = 8'h09; seqPc = 16'h5555;
    for (int k = 5; k < 8; k++) begin
      brKind = k[2:0]; settle();
      chk("R9 reserved kind", nextPc, 16'h5555);
    end
  endtask

  initial begin
    t_idle();
    t_table();
    t_absolute();
    t_relative();
    t_bittest();
    t_loop();
    t_reserved();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule